// File: doc/BRIEF.md
# Externally Synchronized Transparent Serial Channel

This block is a bit-serial transmitter and receiver pair with no framing. Both halves run from one external serial clock and share one active-low sync input. Each half starts out unsynchronized. It locks onto the first rising clock edge at which its enable is high and the sync input is low. After that it keeps its character alignment whatever the sync input does.

Once locked, the receiver gathers a fixed number of bits into a character, least significant bit first. It presents each character on a parallel bus with a one-cycle strobe. There is no backpressure: an acknowledge input marks a character as consumed, and a character that completes before the previous one was acknowledged is flagged as an overrun.

Once locked, the transmitter sends a full all-ones character first. At each character boundary it takes a new character from a ready/valid input. If nothing is offered there, it sends another all-ones character. The transmit output changes on falling clock edges. A hunt command, or clearing the transmit enable, drops the lock so that the transmitter waits for sync low again.

Top module: `sync_serial_chan`

## Requirements
- R1: After reset, rx_valid, rx_overrun, tx_ready and tx_idle are 0 and tx_dout is 1.
- R2: With rx_en high, the receiver locks on the first rising edge that samples sync_n low. The rx_din bit sampled on that same edge is bit 0 of the first character. Before the lock no character is produced.
- R3: Characters are CHAR_W bits, received least significant bit first. rx_valid is high for exactly one cycle, directly after the edge that sampled the last bit, with the whole character on rx_data.
- R4: While locked, the receiver ignores sync_n. Clearing rx_en unlocks it, and after re-enabling it waits for sync_n low again.
- R5: rx_overrun is high together with rx_valid when the character before it got no rx_ack in any cycle from its own rx_valid through the completion edge of the new one. An rx_ack sampled on the completion edge itself prevents the overrun. The first character after rx_en rises never raises rx_overrun.
- R6: While the transmitter is unlocked or tx_en is low, tx_dout is 1.
- R7: With tx_en high, the transmitter locks on the first rising edge that samples sync_n low. The next CHAR_W bit periods on tx_dout are ones, and each bit period starts at a falling clock edge.
- R8: tx_ready is high only in the last bit period of a character. A character is accepted on the rising edge where tx_ready and tx_valid are both high. Its bit 0 appears at the next falling edge, and it is sent least significant bit first, back to back with the previous character.
- R9: When tx_valid is low at a character boundary, the next character is all ones. tx_idle is 1 throughout such idle characters, including the first one after lock, and 0 throughout data characters.
- R10: While locked, the transmitter ignores sync_n. A tx_hunt pulse or clearing tx_en unlocks it. When tx_hunt and sync_n low are sampled on the same edge, the hunt wins and the transmitter stays unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Shared sync input, active low |
| rx_en | input | 1 | Receiver enable |
| rx_din | input | 1 | Serial receive data |
| rx_ack | input | 1 | Marks the held receive character as consumed |
| rx_data | output | CHAR_W | Assembled receive character |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_overrun | output | 1 | Previous character was never acknowledged |
| tx_en | input | 1 | Transmitter enable |
| tx_hunt | input | 1 | Pulse that forces the transmitter to resynchronize |
| tx_data | input | CHAR_W | Character to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter takes tx_data on this edge |
| tx_dout | output | 1 | Serial transmit data, changes on falling edges |
| tx_idle | output | 1 | Current character is all-ones padding |

## Verification
Two sets of events can land on the same clock edge. The first is a receive character completing on the edge where rx_ack clears the previous one. The second is a hunt command sampled together with sync low. The bench holds rx_ack high across whole characters, including their completion edges, and the scoreboard checks that none of those characters reports an overrun, while unacknowledged characters do. For the transmit side, the bench drives tx_hunt and sync_n low into the same edge. It then checks that tx_idle stays low and that tx_ready never rises for two character lengths, which would happen if the lock had been taken.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
  typedef enum int unsigned {
    LANE_RX = 0,
    LANE_TX = 1
  } lane_e;

  function automatic logic char_end(input int unsigned cnt, input int unsigned w);
    return cnt == (w - 1);
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/ssc_lock.sv
`timescale 1ns/1ps
module ssc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clear,
  input  logic sync_n,
  output logic locked,
  output logic lock_evt
);
  assign lock_evt = en && !clear && !locked && !sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              locked <= 1'b0;
    else if (!en || clear)   locked <= 1'b0;
    else if (lock_evt)       locked <= 1'b1;
  end
endmodule

// File: rtl/ssc_rx.sv
`timescale 1ns/1ps
module ssc_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  input  logic         ack,
  input  logic         locked,
  input  logic         lock_evt,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         overrun
);
  import ssc_pkg::*;
  localparam int unsigned CW = cnt_bits(W);

  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;
  logic [W-1:0]  cat;
  logic          pend;
  logic          take_bit;

  assign cat      = {din, sh};
  assign take_bit = en && (locked || lock_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sh      <= '0;
      data    <= '0;
      valid   <= 1'b0;
      overrun <= 1'b0;
      pend    <= 1'b0;
    end else begin
      valid   <= 1'b0;
      overrun <= 1'b0;
      if (!en) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        if (ack) pend <= 1'b0;
        if (take_bit) begin
          sh <= cat[W-1:1];
          if (lock_evt) begin
            cnt <= CW'(1);
          end else if (char_end(32'(cnt), W)) begin
            cnt     <= '0;
            data    <= cat;
            valid   <= 1'b1;
            overrun <= pend && !ack;
            pend    <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssc_tx.sv
`timescale 1ns/1ps
module ssc_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         hunt,
  input  logic         locked,
  input  logic         lock_evt,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         dout,
  output logic         idle
);
  import ssc_pkg::*;
  localparam int unsigned CW = cnt_bits(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic          running;
  logic          boundary;

  assign running  = locked && en && !hunt;
  assign boundary = char_end(32'(cnt), W);
  assign tx_ready = running && boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh   <= '1;
      idle <= 1'b0;
    end else if (lock_evt) begin
      cnt  <= '0;
      sh   <= '1;
      idle <= 1'b1;
    end else if (running) begin
      if (boundary) begin
        cnt <= '0;
        if (tx_valid) begin
          sh   <= tx_data;
          idle <= 1'b0;
        end else begin
          sh   <= '1;
          idle <= 1'b1;
        end
      end else begin
        sh  <= {1'b1, sh[W-1:1]};
        cnt <= cnt + CW'(1);
      end
    end else begin
      cnt  <= '0;
      sh   <= '1;
      idle <= 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b1;
    else        dout <= locked ? sh[0] : 1'b1;
  end
endmodule

// File: rtl/sync_serial_chan.sv
`timescale 1ns/1ps
module sync_serial_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              rx_en,
  input  logic              rx_din,
  input  logic              rx_ack,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_overrun,
  input  logic              tx_en,
  input  logic              tx_hunt,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_dout,
  output logic              tx_idle
);
  import ssc_pkg::*;
  localparam int unsigned NLANE = 2;

  logic [NLANE-1:0] lk_en, lk_clr, lk_locked, lk_evt;
  logic rx_locked, rx_lock_evt, tx_locked, tx_lock_evt;

  assign lk_en[LANE_RX]  = rx_en;
  assign lk_clr[LANE_RX] = 1'b0;
  assign lk_en[LANE_TX]  = tx_en;
  assign lk_clr[LANE_TX] = tx_hunt;

  for (genvar g = 0; g < NLANE; g++) begin : g_lock
    ssc_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (lk_en[g]),
      .clear    (lk_clr[g]),
      .sync_n   (sync_n),
      .locked   (lk_locked[g]),
      .lock_evt (lk_evt[g])
    );
  end

  assign rx_locked   = lk_locked[LANE_RX];
  assign rx_lock_evt = lk_evt[LANE_RX];
  assign tx_locked   = lk_locked[LANE_TX];
  assign tx_lock_evt = lk_evt[LANE_TX];

  ssc_rx #(.W(CHAR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .din      (rx_din),
    .ack      (rx_ack),
    .locked   (rx_locked),
    .lock_evt (rx_lock_evt),
    .data     (rx_data),
    .valid    (rx_valid),
    .overrun  (rx_overrun)
  );

  ssc_tx #(.W(CHAR_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tx_en),
    .hunt     (tx_hunt),
    .locked   (tx_locked),
    .lock_evt (tx_lock_evt),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .dout     (tx_dout),
    .idle     (tx_idle)
  );
endmodule

// File: rtl/ssc_checker.sv
`timescale 1ns/1ps
module ssc_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic rx_valid,
  input logic rx_overrun,
  input logic rx_locked,
  input logic tx_en,
  input logic tx_hunt,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_idle,
  input logic tx_dout,
  input logic tx_locked
);
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_overrun_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);

  p_rx_hold_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_locked && rx_en) |=> rx_locked);

  p_rx_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_locked);

  p_dout_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_locked) |-> tx_dout);

  p_ready_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_locked && tx_en && !tx_hunt));

  p_idle_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_idle);

  p_hunt_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hunt |=> !tx_locked);
endmodule

bind sync_serial_chan ssc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .rx_valid   (rx_valid),
  .rx_overrun (rx_overrun),
  .rx_locked  (rx_locked),
  .tx_en      (tx_en),
  .tx_hunt    (tx_hunt),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_idle    (tx_idle),
  .tx_dout    (tx_dout),
  .tx_locked  (tx_locked)
);

// File: tb/sync_serial_chan_tb.sv
`timescale 1ns/1ps
module sync_serial_chan_tb;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic rx_en = 1'b0, rx_din = 1'b0, rx_ack = 1'b0;
  logic tx_en = 1'b0, tx_hunt = 1'b0, tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] rx_data;
  logic rx_valid, rx_overrun, tx_ready, tx_dout, tx_idle;

  int n_chk = 0, n_err = 0;
  bit tog_sync = 0;
  bit finished = 0;

  sync_serial_chan #(.CHAR_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
    .rx_en(rx_en), .rx_din(rx_din), .rx_ack(rx_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_overrun(rx_overrun),
    .tx_en(tx_en), .tx_hunt(tx_hunt), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_dout(tx_dout), .tx_idle(tx_idle)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drivers act shortly after the falling edge; monitors look a little later.
  task automatic step();
    @(negedge clk);
    #0.2;
    if (tog_sync) sync_n = 1'($urandom_range(0, 1));
  endtask

  // ---------------- receive scoreboard ----------------
  logic [W:0] rxq[$];   // {overrun, data}
  int rx_seen = 0;

  task automatic rx_send(input logic [W-1:0] c, input bit ack, input bit first);
    rxq.push_back({(!ack && !first), c});
    for (int i = 0; i < W; i++) begin
      rx_din = c[i];
      rx_ack = ack;
      if (first && i == 0) sync_n = 1'b0;
      else                 sync_n = 1'($urandom_range(0, 1));
      step();
    end
    rx_ack = 1'b0;
    sync_n = 1'b1;
  endtask

  always @(negedge clk) begin
    #0.6;
    if (rst_n && rx_valid) begin
      rx_seen++;
      if (rxq.size() == 0) begin
        chk(0, "R2 unexpected character", {23'b0, rx_overrun, rx_data}, 0);
      end else begin
        logic [W:0] e;
        e = rxq.pop_front();
        chk(rx_data == e[W-1:0], "R3 rx_data", rx_data, e[W-1:0]);
        chk(rx_overrun == e[W], "R5 rx_overrun", rx_overrun, e[W]);
      end
    end
  end

  // ---------------- transmit scoreboard ----------------
  logic [W-1:0] txq[$];
  bit tx_mon_on = 0;
  int tx_j = 0, tx_nch = 0;
  bit idle_log[16];
  logic [W-1:0] tx_bits;
  bit cur_idle;

  task automatic tx_send(input logic [W-1:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) step();
    txq.push_back(d);
    step();
    tx_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #0.6;
    if (tx_mon_on) begin
      int pos;
      pos = tx_j % W;
      if (pos == 0) begin
        cur_idle = tx_idle;
        tx_bits  = '0;
      end else begin
        chk(tx_idle == cur_idle, "R9 tx_idle steady within character", tx_idle, cur_idle);
      end
      tx_bits[pos] = tx_dout;
      if (pos == W - 1) begin
        if (tx_nch < 16) idle_log[tx_nch] = cur_idle;
        if (cur_idle) begin
          chk(tx_bits == ONES, "R9 idle character all ones", tx_bits, ONES);
        end else if (txq.size() == 0) begin
          chk(0, "R8 unexpected data character", tx_bits, 0);
        end else begin
          logic [W-1:0] e;
          e = txq.pop_front();
          chk(tx_bits == e, "R8 transmitted character", tx_bits, e);
        end
        tx_nch++;
      end
      tx_j++;
    end
  end

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1: reset values
    chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    chk(rx_overrun == 0, "R1 rx_overrun", rx_overrun, 0);
    chk(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    chk(tx_idle == 0, "R1 tx_idle", tx_idle, 0);
    chk(tx_dout == 1, "R1 tx_dout", tx_dout, 1);
    rst_n = 1'b1;
    step();

    // ---------------- receive phase ----------------
    rx_en = 1'b1;
    for (int i = 0; i < 6; i++) begin  // R2: no lock while sync high
      rx_din = 1'($urandom_range(0, 1));
      step();
      chk(rx_valid == 0, "R2 no character before lock", rx_valid, 0);
    end
    rx_send(8'hA5, 1, 1);
    rx_send(8'h3C, 1, 0);
    rx_send(8'h81, 0, 0);   // R5: previous pending -> overrun
    rx_send(8'h7E, 0, 0);
    rx_send(8'h00, 1, 0);   // ack held through completion edge
    step();
    rx_en = 1'b0;           // R4: unlock
    step();
    rx_en = 1'b1;
    for (int i = 0; i < 2 * W; i++) begin
      rx_din = 1'($urandom_range(0, 1));
      step();
      chk(rx_valid == 0, "R4 waits for sync after re-enable", rx_valid, 0);
    end
    rx_send(8'hC3, 0, 1);
    rx_send(8'h5A, 1, 0);
    step();
    step();
    chk(rxq.size() == 0, "R3 all characters delivered", rxq.size(), 0);
    chk(rx_seen == 7, "R3 character count", rx_seen, 7);
    rx_en = 1'b0;
    step();

    // ---------------- transmit phase ----------------
    for (int i = 0; i < 4; i++) begin   // R6: disabled
      sync_n = 1'($urandom_range(0, 1));
      step();
      chk(tx_dout == 1, "R6 dout high while disabled", tx_dout, 1);
    end
    sync_n = 1'b1;
    tx_en  = 1'b1;
    for (int i = 0; i < 4; i++) begin   // R6: enabled, unlocked
      step();
      chk(tx_dout == 1 && tx_idle == 0, "R6 dout high while unlocked", {tx_idle, tx_dout}, 1);
    end
    sync_n = 1'b0;
    step();                             // lock edge passed, bit 0 on line
    tx_j = 0; tx_nch = 0; tx_mon_on = 1;
    tog_sync = 1;                       // R10: sync ignored once locked
    chk(tx_idle == 1, "R7 first character is idle", tx_idle, 1);
    step(); step(); step();
    tx_send(8'h4B);
    tx_send(8'hD2);                     // back to back
    repeat (W + 3) step();
    tx_send(8'h17);                     // after a gap
    repeat (W + 1) step();
    chk(idle_log[0] == 1, "R7 idle before first data", idle_log[0], 1);
    chk(idle_log[1] == 0 && idle_log[2] == 0, "R8 back-to-back data", {idle_log[1], idle_log[2]}, 0);
    chk(idle_log[3] == 1, "R9 idle fill in gap", idle_log[3], 1);
    chk(idle_log[4] == 0, "R8 data after gap", idle_log[4], 0);

    // R10: hunt wins over sync low on the same edge
    tog_sync  = 0;
    tx_mon_on = 0;
    tx_hunt   = 1'b1;
    sync_n    = 1'b0;
    tx_data   = 8'h96;
    tx_valid  = 1'b1;
    step();
    tx_hunt = 1'b0;
    sync_n  = 1'b1;
    chk(tx_idle == 0, "R10 hunt wins over sync", tx_idle, 0);
    for (int i = 0; i < 2 * W; i++) begin
      chk(tx_ready == 0 && tx_dout == 1, "R10 unlocked after hunt", {tx_ready, tx_dout}, 1);
      step();
    end
    sync_n = 1'b0;
    step();                             // relock
    sync_n = 1'b1;
    tx_j = 0; tx_nch = 0; tx_mon_on = 1;
    tx_send(8'h96);
    repeat (W + 1) step();
    chk(idle_log[0] == 1 && idle_log[1] == 0, "R7 relock idle then data", {idle_log[0], idle_log[1]}, 2);
    chk(txq.size() == 0, "R8 all characters sent", txq.size(), 0);

    tx_mon_on = 0;
    tx_en = 1'b0;                       // R10: disable unlocks
    step();
    for (int i = 0; i < W; i++) begin
      chk(tx_dout == 1 && tx_ready == 0, "R10 disable returns to unlocked", {tx_ready, tx_dout}, 1);
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule